// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides when a small 8-bit processor core leaves its instruction stream to service an interrupt, and which handler it enters. Each source is either an event source, whose single-cycle pulse is caught in a sticky flag, or a level source, which requests service only while its condition is high. A per-source enable masks the request, and a global enable gates all of them. The lowest-numbered source that is both requesting and enabled wins. Vector index 0 belongs to reset, so source `i` is reported as vector `i+1`.

The core reports instruction boundaries through plain control pins: an instruction retiring, a multi-cycle instruction still running, and the retirement of a return-from-interrupt, an enable-interrupts or a disable-interrupts instruction. The controller keeps the global enable, holds off acceptance for one instruction after a return or an enable, honours a disable in the same cycle, and spaces accepted interrupts by a response window. A block input from a protection unit holds off acceptance without losing any request. Every pin is a plain control or status pin. There is no data stream and no handshake.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `vec_o` during a take strobe equals 1 + the lowest index `i` with `src_en_i[i]` set and source `i` requesting. Vector 0 is never produced.
- R2: `take_o` is high for one cycle, one clock edge after an accepting cycle. An accepting cycle has `retire_i`=1. `vec_o` is 0 whenever `take_o` is 0.
- R3: `gie_o` resets to 0. It drops to 0 at the edge that raises `take_o`. A retiring return (`reti_i`) or enable (`sei_i`) sets it at the next edge.
- R4: An event source (bit `i` of `EVT_MASK` = 1) sets `flag_o[i]` at the edge after its pulse, whatever the enables. The flag stays set until it is cleared.
- R5: A 1 on `flag_clr_i[i]` clears `flag_o[i]`, and so does taking source `i`. A new pulse in the same cycle wins over either clear.
- R6: A level source (bit `i` of `EVT_MASK` = 0) is never latched. `flag_o[i]` stays 0, and it can win only in a cycle where `src_req_i[i]` is high.
- R7: No interrupt is accepted in the cycle that retires a return or an enable. None is accepted in any later cycle until one more `retire_i` cycle has passed.
- R8: `cli_i` clears `gie_o` at the next edge. No interrupt is accepted in a cycle with `cli_i`=1, and `cli_i` wins over `sei_i` and `reti_i` in that cycle.
- R9: No interrupt is accepted in a cycle where `busy_i`=1 (multi-cycle instruction not finished).
- R10: After a take strobe, the next take strobe comes no earlier than `RESP_CYC`+1 cycles later.
- R11: While `block_i`=1, nothing is accepted and flags are kept. Once it drops, the pending sources are served in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | NUM_SRC | Event pulses or level conditions per source |
| src_en_i | input | NUM_SRC | Per-source enable |
| flag_clr_i | input | NUM_SRC | Write-one-to-clear strobe for flags |
| retire_i | input | 1 | An instruction retires this cycle |
| busy_i | input | 1 | A multi-cycle instruction is still running |
| reti_i | input | 1 | The retiring instruction is a return from interrupt |
| sei_i | input | 1 | The retiring instruction enables interrupts |
| cli_i | input | 1 | The retiring instruction disables interrupts |
| block_i | input | 1 | Protection unit holds off acceptance |
| gie_o | output | 1 | Global interrupt enable |
| flag_o | output | NUM_SRC | Sticky flags of event sources |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | VEC_W | Vector index, valid with take_o |

## Verification
The bench targets the cycles where acceptance hinges on one signal. In the cycle right after an enable, a controller with no shadow would enter the handler one instruction early. A disable that arrives together with a pending request would let a late take slip through if the disable were only registered. A pulse that lands on the same edge as its own clear would be lost if the clear took priority. Level sources that drop before the enable is raised must leave no trace, while flags must survive a held block input and then be served lowest index first. A cycle-level reference model runs under random core traffic, so busy cycles and back-to-back takes inside the response window are also caught.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Boundary information reported by the core each cycle
  typedef struct packed {
    logic retire;
    logic busy;
    logic reti;
    logic sei;
    logic cli;
  } core_evt_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] EVT_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] taken_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] req_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EVT_MASK[i]) begin : g_evt
      logic flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n)            flag_q <= 1'b0;
        else if (src_req_i[i]) flag_q <= 1'b1;
        else if (clr_i[i] || taken_i[i]) flag_q <= 1'b0;
      end
      assign flag_o[i] = flag_q;
      assign req_o[i]  = flag_q & src_en_i[i];

      AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        src_req_i[i] |=> flag_o[i]); // R4
    end else begin : g_lvl
      assign flag_o[i] = 1'b0;
      assign req_o[i]  = src_req_i[i] & src_en_i[i];
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = 3
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] hit_o
);
  assign any_o = |req_i;

  // Scan from the top down so the lowest index is written last
  always_comb begin
    vec_o = '0;
    hit_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vec_o    = VEC_W'(i + 1);
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import prio_irq_pkg::*;
#(
  parameter int RESP_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  core_evt_t evt_i,
  input  logic      block_i,
  input  logic      any_i,
  output logic      accept_o,
  output logic      gie_o
);
  localparam int CNT_W = $clog2(RESP_CYC + 1);

  logic             gie_q;
  logic             shadow_q;
  logic [CNT_W-1:0] win_q;
  logic             enable_evt;

  assign enable_evt = evt_i.reti | evt_i.sei;

  assign accept_o = gie_q & any_i & evt_i.retire & ~evt_i.busy & ~evt_i.cli
                  & ~enable_evt & ~shadow_q & ~block_i & (win_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      shadow_q <= 1'b0;
      win_q    <= '0;
    end else begin
      if (evt_i.cli || accept_o) gie_q <= 1'b0;
      else if (enable_evt)       gie_q <= 1'b1;

      if (enable_evt)        shadow_q <= 1'b1;
      else if (evt_i.retire) shadow_q <= 1'b0;

      if (accept_o)            win_q <= CNT_W'(RESP_CYC);
      else if (win_q != '0)    win_q <= win_q - 1'b1;
    end
  end

  assign gie_o = gie_q;

  AST_CLI_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.cli |=> !gie_q); // R8
  AST_RETURN_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_evt && !evt_i.cli) |=> gie_q); // R3
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_evt && !evt_i.retire) |=> !accept_o); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] EVT_MASK = 6'b110101,
  parameter int RESP_CYC = 4,
  localparam int VEC_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               retire_i,
  input  logic               busy_i,
  input  logic               reti_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               block_i,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o
);
  core_evt_t          evt;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] taken;
  logic               any;
  logic               accept;
  logic [VEC_W-1:0]   vec_d;
  logic               take_q;
  logic [VEC_W-1:0]   vec_q;

  assign evt = '{retire: retire_i, busy: busy_i, reti: reti_i, sei: sei_i, cli: cli_i};
  assign taken = accept ? hit : '0;

  irq_flags #(.NUM_SRC(NUM_SRC), .EVT_MASK(EVT_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .src_en_i(src_en_i),
    .clr_i(flag_clr_i), .taken_i(taken), .flag_o(flag_o), .req_o(req)
  );

  irq_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .req_i(req), .any_o(any), .vec_o(vec_d), .hit_o(hit)
  );

  irq_gate #(.RESP_CYC(RESP_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .block_i(block_i), .any_i(any),
    .accept_o(accept), .gie_o(gie_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      vec_q  <= accept ? vec_d : '0;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;

  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o != '0)); // R1
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (vec_o == '0)); // R2
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o); // R3
  AST_NO_TAKE_AFTER_CLI: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(cli_i)); // R8
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(retire_i && !busy_i)); // R9
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R10
  AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(block_i)); // R11
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N = 6;
  localparam logic [N-1:0] EVT = 6'b110101;
  localparam int RC = 4;
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_req = '0, src_en = '0, flag_clr = '0;
  logic retire = 0, busy = 0, reti = 0, sei = 0, cli = 0, block = 0;
  logic gie, take;
  logic [N-1:0] flag;
  logic [VW-1:0] vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .EVT_MASK(EVT), .RESP_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_en_i(src_en),
    .flag_clr_i(flag_clr), .retire_i(retire), .busy_i(busy), .reti_i(reti),
    .sei_i(sei), .cli_i(cli), .block_i(block), .gie_o(gie), .flag_o(flag),
    .take_o(take), .vec_o(vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_gie, m_shadow, m_take;
  int m_win, m_vec;
  bit m_flag[N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_shadow = 0; m_take = 0; m_win = 0; m_vec = 0;
      foreach (m_flag[i]) m_flag[i] = 0;
    end else begin
      int win;
      bit ok;
      win = -1;
      for (int i = 0; i < N; i++) begin
        bit r;
        r = EVT[i] ? m_flag[i] : src_req[i];
        if (win < 0 && r && src_en[i]) win = i;
      end
      ok = m_gie && !cli && !sei && !reti && !m_shadow && !block && m_win == 0
           && retire && !busy && win >= 0;
      for (int i = 0; i < N; i++)
        if (EVT[i])
          m_flag[i] = src_req[i] ? 1'b1 : (m_flag[i] && !flag_clr[i] && !(ok && win == i));
      if (cli || ok) m_gie = 0;
      else if (sei || reti) m_gie = 1;
      if (sei || reti) m_shadow = 1;
      else if (retire) m_shadow = 0;
      if (ok) m_win = RC;
      else if (m_win > 0) m_win--;
      m_take = ok;
      m_vec = ok ? win + 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R6 R9 R10 take", take, m_take);
      chk("R1 vec", vec, m_vec);
      chk("R3 R8 gie", gie, m_gie);
      for (int i = 0; i < N; i++) chk("R4 R5 R6 flag", flag[i], m_flag[i]);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    sei = 0; reti = 0; cli = 0; flag_clr = '0;
    src_req = src_req & ~EVT;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R3 reset gie", gie, 0);
    chk("R2 reset take", take, 0);
    chk("R4 reset flags", flag, 0);

    // R4: pulse on event source 0 with enables off
    src_req = 6'b000001; tick(); pulse_clear();
    chk("R4 flag set while disabled", flag[0], 1);
    tick();
    chk("R4 flag held", flag[0], 1);

    // R7: enable, then next boundary must not accept
    src_en = 6'b000001;
    retire = 1; sei = 1; tick(); pulse_clear();
    chk("R3 sei sets gie", gie, 1);
    tick();
    chk("R7 shadow after sei", take, 0);
    tick();
    chk("R1 take vector", vec, 1);
    chk("R2 take strobe", take, 1);
    chk("R3 take clears gie", gie, 0);
    chk("R5 take clears flag", flag[0], 0);
    retire = 0; tick();
    chk("R2 strobe one cycle", take, 0);

    // R1: two event sources pending, lower wins; R8 cli in accepting cycle
    src_req = 6'b010100; tick(); pulse_clear();
    src_en = 6'b010100;
    retire = 1; sei = 1; tick(); pulse_clear();
    tick();
    cli = 1; tick(); pulse_clear();
    chk("R8 no take with cli", take, 0);
    chk("R8 cli clears gie", gie, 0);

    // R11: block holds off, then releases to lowest index
    block = 1; sei = 1; tick(); pulse_clear();
    repeat (4) tick();
    chk("R11 blocked no take", take, 0);
    chk("R11 flags kept", flag & 6'b010100, 6'b010100);
    block = 0; tick();
    chk("R11 release takes source 2", vec, 3);
    chk("R5 other flag kept", flag[4], 1);

    // R5: pulse and clear in the same cycle, pulse wins
    src_req = 6'b000001; flag_clr = 6'b000001; tick(); pulse_clear();
    chk("R5 pulse beats clear", flag[0], 1);
    flag_clr = 6'b000001; tick(); pulse_clear();
    chk("R5 w1c clears", flag[0], 0);
    retire = 0;

    // Random traffic checked against the model
    src_en = '1;
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      pulse_clear();
      retire = ($urandom % 4) != 0;
      busy   = ($urandom % 4) == 0;
      sei    = retire && ($urandom % 8) == 0;
      reti   = retire && ($urandom % 16) == 0;
      cli    = retire && ($urandom % 24) == 0;
      block  = ($urandom % 10) == 0;
      flag_clr = (($urandom % 12) == 0) ? N'($urandom) : '0;
      src_req = (N'($urandom) & N'($urandom) & N'($urandom) & EVT)
              | (src_req & ~EVT);
      if (($urandom % 5) == 0) src_req = (src_req & EVT) | (N'($urandom) & ~EVT);
      if (($urandom % 50) == 0) src_en = N'($urandom);
    end
    pulse_clear(); retire = 0;
    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule